// File: doc/BRIEF.md
# Two-Requester Handshake Arbiter

This block shares one resource between two devices through a level handshake. A device raises its request line and waits for its grant. It keeps the resource for as long as its request stays high, then lowers the request, and the arbiter withdraws that grant in response. A grant is never taken from a device that still holds its request.

The request lines may come from another clock domain. Each one passes through its own two-flop synchroniser before it reaches the state register. Grants are driven from flops and are mutually exclusive. When both devices ask from the idle state, device 1 wins. When a holder lets go while the other device is waiting, the resource passes straight to the waiter. This hand-off goes through one intermediate cycle in which neither grant is high.

The state code is chosen so that every step inside a hand-off flips a single state bit.

Top module: `twin_req_arbiter`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears both grants, the synchronisers and the state. Both grants read low in the cycle after that edge.
- R2: A request level applied from idle passes through two synchroniser flops and the state register. The grant rises at the third rising clock edge after the level is applied, and not before.
- R3: From idle, with only device 2 requesting, the grant goes to device 2 (gnt2 high, gnt1 low).
- R4: From idle, when both synchronised requests are high in the same cycle, device 1 receives the grant.
- R5: While the holder's synchronised request stays high, its grant stays high. This holds whatever the other device's request does.
- R6: When the holder's synchronised request falls and the other request is low, both grants are low after the next edge, and the arbiter is idle again.
- R7: When the holder's synchronised request falls while the other device is requesting, both grants are low for exactly one cycle. The grant then rises for the waiting device. The state codes are: idle 00, device-1 owner 01, hand-off 11, device-2 owner 10. Each step on the way, 01→11→10 and 10→11→01, changes one state bit.
- R8: In the hand-off cycle the synchronised requests are read again, and they decide the next state:
  - only device 1 high: grant to device 1
  - only device 2 high: grant to device 2
  - both high: device 1 wins
  - neither high: return to idle
- R9: gnt1 and gnt2 are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req1_in | input | 1 | Request level from device 1, may be asynchronous |
| req2_in | input | 1 | Request level from device 2, may be asynchronous |
| gnt1 | output | 1 | Registered grant to device 1 |
| gnt2 | output | 1 | Registered grant to device 2 |

## Verification
A wrong state shows at the grant pins at the next rising edge, because each grant flop is loaded from the same next-state value as the state register. A stuck owner state shows as a grant that outlives its request by more than three edges. A wrong hand-off path shows as a missing one-cycle gap, or as the grant landing on the device that just released. A wrong tie rule, or a wrong decision in the hand-off cycle, shows as the wrong grant exactly one cycle after the gap.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Codes are ordered so that every step of a hand-off flips one bit.
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_OWN1 = 2'b01,
    ST_GAP  = 2'b11,
    ST_OWN2 = 2'b10
  } arb_state_e;

  // Next state from the current state and the synchronised request levels.
  function automatic arb_state_e arb_next(arb_state_e cur, logic r1, logic r2);
    arb_state_e nxt;
    unique case (cur)
      ST_OWN1: nxt = r1 ? ST_OWN1 : (r2 ? ST_GAP : ST_IDLE);
      ST_OWN2: nxt = r2 ? ST_OWN2 : (r1 ? ST_GAP : ST_IDLE);
      // Idle and gap decide the same way: device 1 wins a tie.
      default: nxt = r1 ? ST_OWN1 : (r2 ? ST_OWN2 : ST_IDLE);
    endcase
    return nxt;
  endfunction

  // Grant pair {gnt2, gnt1} shown for a state.
  function automatic logic [1:0] arb_grants(arb_state_e s);
    logic [1:0] g;
    unique case (s)
      ST_OWN1: g = 2'b01;
      ST_OWN2: g = 2'b10;
      default: g = 2'b00;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/arb_sync_chain.sv
module arb_sync_chain #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  // Each further stage takes the value of the stage before it.
  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= '0;
      else     pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[LAST];
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       r1,
  input  logic       r2,
  output arb_state_e st_q,
  output logic [1:0] gnt_q
);
  arb_state_e st_d;

  always_comb st_d = arb_next(st_q, r1, r2);

  // The grant flops load from the same next state as the state register,
  // so the grants change at the same edge as the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      gnt_q <= 2'b00;
    end else begin
      st_q  <= st_d;
      gnt_q <= arb_grants(st_d);
    end
  end
endmodule

// File: rtl/twin_req_arbiter.sv
module twin_req_arbiter
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req1_in,
  input  logic req2_in,
  output logic gnt1,
  output logic gnt2
);
  localparam int N_REQ = 2;

  logic [N_REQ-1:0] req_s;    // synchronised requests {r2, r1}
  arb_state_e       st_q;
  logic [1:0]       gnt_bus;  // {gnt2, gnt1}

  arb_sync_chain #(.WIDTH(N_REQ), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({req2_in, req1_in}),
    .q   (req_s)
  );

  arb_fsm fsm_i (
    .clk   (clk),
    .rst   (rst),
    .r1    (req_s[0]),
    .r2    (req_s[1]),
    .st_q  (st_q),
    .gnt_q (gnt_bus)
  );

  assign gnt1 = gnt_bus[0];
  assign gnt2 = gnt_bus[1];
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] req_s,
  input logic [1:0] st_q,
  input logic       gnt1,
  input logic       gnt2
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!gnt1 && !gnt2)); // R1

  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(gnt1 && gnt2)); // R9

  AST_TIE_TO_ONE: assert property (@(posedge clk) disable iff (rst)
    (!gnt1 && !gnt2 && req_s == 2'b11) |=> gnt1); // R4

  AST_HOLD_ONE: assert property (@(posedge clk) disable iff (rst)
    (gnt1 && req_s[0]) |=> gnt1); // R5

  AST_HOLD_TWO: assert property (@(posedge clk) disable iff (rst)
    (gnt2 && req_s[1]) |=> gnt2); // R5

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((gnt1 || gnt2) && req_s == 2'b00) |=> (!gnt1 && !gnt2)); // R6

  AST_HANDOFF_GAP: assert property (@(posedge clk) disable iff (rst)
    (gnt1 && req_s == 2'b10) |=> (!gnt1 && !gnt2)); // R7

  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
    ((st_q != $past(st_q)) && !(st_q == 2'b00 && $past(st_q) == 2'b11))
      |-> ($countones(st_q ^ $past(st_q)) == 1)); // R7

  AST_GAP_SOLO_TWO: assert property (@(posedge clk) disable iff (rst)
    (st_q == 2'b11 && req_s == 2'b10) |=> gnt2); // R8
endmodule

bind twin_req_arbiter arb_checker chk_i (
  .clk   (clk),
  .rst   (rst),
  .req_s (req_s),
  .st_q  (st_q),
  .gnt1  (gnt1),
  .gnt2  (gnt2)
);

// File: tb/twin_req_arbiter_tb.sv
module twin_req_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req1 = 1'b0;
  logic req2 = 1'b0;
  logic gnt1, gnt2;
  int   checks = 0;
  int   errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  twin_req_arbiter dut_i (
    .clk(clk), .rst(rst), .req1_in(req1), .req2_in(req2),
    .gnt1(gnt1), .gnt2(gnt2)
  );

  // Behavioural reference.
  // holder: 0 none, 1 device 1, 2 device 2, 3 hand-off gap.
  // Requests reach the decision through a two-entry delay queue.
  int q1 [$] = '{0, 0};
  int q2 [$] = '{0, 0};
  int holder = 0;

  always @(posedge clk) begin
    int a, b, nh;
    a = q1[1];
    b = q2[1];
    if (rst) begin
      holder = 0;
      q1 = '{0, 0};
      q2 = '{0, 0};
    end else begin
      if (holder == 1)      nh = a ? 1 : (b ? 3 : 0);
      else if (holder == 2) nh = b ? 2 : (a ? 3 : 0);
      else                  nh = a ? 1 : (b ? 2 : 0);
      holder = nh;
      q1.push_front(int'(req1)); void'(q1.pop_back());
      q2.push_front(int'(req2)); void'(q2.pop_back());
    end
  end

  function automatic logic [1:0] model_gnt(int h);
    if (h == 1) return 2'b01;
    if (h == 2) return 2'b10;
    return 2'b00;
  endfunction

  always @(negedge clk) begin
    checks++;
    if ({gnt2, gnt1} !== model_gnt(holder)) begin
      errors++;
      $display("FAIL R9/model t=%0t actual=%b expected=%b", $time, {gnt2, gnt1}, model_gnt(holder));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [1:0] exp);
    checks++;
    if ({gnt2, gnt1} !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, {gnt2, gnt1}, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    chk("R1 reset", 2'b00);
    rst = 1'b0;

    // Device 1 alone, then device 2 waits, then hand-off to device 2.
    req1 = 1; step(2); chk("R2 before third edge", 2'b00);
    step(1); chk("R2 grant one", 2'b01);
    req2 = 1; step(5); chk("R5 hold one", 2'b01);
    req1 = 0; step(3); chk("R7 gap 1to2", 2'b00);
    step(1); chk("R7 grant two", 2'b10);
    req2 = 0; step(3); chk("R6 release two", 2'b00);

    // Device 2 alone, then hand-off back to device 1.
    req2 = 1; step(3); chk("R3 grant two", 2'b10);
    req1 = 1; step(4); chk("R5 hold two", 2'b10);
    req2 = 0; step(3); chk("R7 gap 2to1", 2'b00);
    step(1); chk("R7 grant one", 2'b01);
    req1 = 0; step(3); chk("R6 release one", 2'b00);

    // Tie from idle.
    req1 = 1; req2 = 1; step(3); chk("R4 tie", 2'b01);
    req1 = 0; req2 = 0; step(6); chk("R6 idle after tie", 2'b00);

    // Gap with both requests back: device 1 wins.
    req1 = 1; step(3); chk("R2 grant one again", 2'b01);
    req2 = 1; step(3);
    req1 = 0; step(1);
    req1 = 1; step(2); chk("R8 gap", 2'b00);
    step(1); chk("R8 tie in gap", 2'b01);
    req1 = 0; step(4); chk("R7 grant two after gap", 2'b10);
    req2 = 0; step(4); chk("R6 idle", 2'b00);

    // Gap with no request left: back to idle.
    req1 = 1; step(3);
    req2 = 1; step(3);
    req1 = 0; step(1);
    req2 = 0; step(2); chk("R8 gap to idle a", 2'b00);
    step(1); chk("R8 gap to idle b", 2'b00);
    step(3); chk("R8 stays idle", 2'b00);

    // Reset while a grant is held.
    req1 = 1; step(3); chk("R2 grant before reset", 2'b01);
    rst = 1; step(1); chk("R1 reset mid grant", 2'b00);
    rst = 0; step(3); chk("R2 grant after reset", 2'b01);
    req1 = 0; step(4); chk("R6 final idle", 2'b00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule